// File: doc/BRIEF.md
# Configurable Product-Term Logic Cell

This block is one logic cell of a programmable array, written for synthesis. A small AND-OR array forms a product-term sum from a generic input vector and the dedicated clock pin. That sum feeds a storage bit that can act as a data flip-flop or as a toggle flip-flop. Four more single AND terms supply the cell's side controls:

- an asynchronous set of the bit,
- an asynchronous reset of the bit,
- a private cell clock,
- a drive enable for the pin buffer.

Static configuration inputs select the following:

- which inputs each term uses, either true or inverted;
- data or toggle storage;
- the shared clock pin or the cell's own term clock;
- the edge of the term clock;
- whether the pin sees the stored bit or the raw sum.

The cell runs entirely on one fast system clock. The dedicated clock pin and the term clock are sampled signals, and edges on them become one-cycle load enables. A design that loads many of these cells therefore has a single clock domain. The outputs are:

- the data value toward the pin,
- a drive-enable flag for an external tri-state buffer,
- a feedback copy of the data value for the array.

Top module: `pld_macrocell`

## Requirements
- R1: A synchronous active-high reset sets the stored bit, the pin data, the pin enable and the feedback output to 0.
- R2: The array input vector puts `in_vec` at bits NIN-1..0 and the dedicated clock pin at bit NIN. Term i takes its true mask from `cfg_sum_true[i*(NIN+1) +: NIN+1]` and its inverted mask from the same slice of `cfg_sum_inv`. A term is 1 when every input in its true mask is 1 and every input in its inverted mask is 0. A term whose two masks are both all zero is 0. The sum is the OR of all terms.
- R3: In data mode with the shared clock selected (`cfg_arr_clk`=0), a rising edge on `clk_pin` loads the sum into the bit. The pin shows the new value 3 system clocks after the edge is presented.
- R4: Without a selected clock edge, and with both set and reset released, the stored bit holds. A falling edge on `clk_pin` never loads when the shared clock is selected.
- R5: In toggle mode (`cfg_toggle`=1), a selected clock edge inverts the bit when the sum is 1 and leaves it unchanged when the sum is 0.
- R6: With `cfg_arr_clk`=1 and `cfg_aclk_fall`=0, the cell clock term (side term index 2) clocks the bit on its 0-to-1 transition only.
- R7: With `cfg_arr_clk`=1 and `cfg_aclk_fall`=1, the cell clock term clocks the bit on its 1-to-0 transition only.
- R8: While the cell clock term is selected, transitions of `clk_pin` do not clock the bit.
- R9: The set term (side term index 0) forces the bit to 1 and the reset term (side term index 1) forces it to 0, whatever the clock. Each acts through an active-low control, and the forced value stays after the term drops.
- R10: When the set and reset terms are both 1, reset wins and the bit is 0.
- R11: The enable term (side term index 3) drives `pin_oe`, where 1 means the buffer drives, 2 system clocks after its inputs are presented.
- R12: In combinational mode (`cfg_comb`=1), the pin shows the sum directly and bypasses the bit. A change appears exactly 2 system clocks after it is presented.
- R13: `fb_out` always equals `pin_data`.
- R14: `clk_pin` can be used as an ordinary term input through array bit NIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vec | input | NIN | Generic array inputs |
| clk_pin | input | 1 | Dedicated clock pin, also an array input |
| cfg_sum_true | input | NTERM*(NIN+1) | True-polarity masks of the sum terms |
| cfg_sum_inv | input | NTERM*(NIN+1) | Inverted-polarity masks of the sum terms |
| cfg_side_true | input | 4*(NIN+1) | True masks of the side terms: 0 set, 1 reset, 2 clock, 3 enable |
| cfg_side_inv | input | 4*(NIN+1) | Inverted masks of the side terms, same order |
| cfg_toggle | input | 1 | 1 selects toggle storage, 0 selects data storage |
| cfg_arr_clk | input | 1 | 1 selects the cell clock term, 0 selects the shared clock pin |
| cfg_aclk_fall | input | 1 | 1 makes the cell clock term act on its falling edge |
| cfg_comb | input | 1 | 1 sends the raw sum to the pin |
| pin_data | output | 1 | Data toward the pin |
| pin_oe | output | 1 | Drive enable for the pin buffer |
| fb_out | output | 1 | Feedback copy of the pin data |

## Verification
A wrong stored bit shows on `pin_data` and `fb_out` three system clocks after the stimulus that caused it. The error then persists until the next load, set or reset. For that reason every stimulus is held long enough to settle before the outputs are compared. Some faults show nothing at the moment they happen: a spurious load on the wrong clock edge, or a toggle that fails to happen. These appear only when the held value is compared after the next set of inputs. A wrong edge-polarity choice, or a set/reset priority swap, shows on the pin within the same three-cycle window. A fault in the combinational path or the enable path shows two cycles after its inputs change.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

  // Side product terms, index into the side mask vectors
  localparam int SIDE_SET = 0;
  localparam int SIDE_RST = 1;
  localparam int SIDE_CLK = 2;
  localparam int SIDE_OE  = 3;
  localparam int SIDE_N   = 4;

  typedef enum logic {
    CLK_SHARED = 1'b0,
    CLK_CELL   = 1'b1
  } clk_src_e;

endpackage

// File: rtl/pld_pterm.sv
module pld_pterm #(
  parameter int NA = 9
) (
  input  logic [NA-1:0] arr_in,
  input  logic [NA-1:0] true_mask,
  input  logic [NA-1:0] inv_mask,
  output logic          hit
);
  logic used;
  logic true_ok;
  logic inv_ok;

  always_comb begin
    used    = |(true_mask | inv_mask);
    true_ok = ((arr_in & true_mask) == true_mask);
    inv_ok  = ((~arr_in & inv_mask) == inv_mask);
    hit     = used & true_ok & inv_ok;
  end
endmodule

// File: rtl/pld_edge_gen.sv
module pld_edge_gen
  import pld_mc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     pin_s,
  input  logic     cell_term,
  input  clk_src_e src,
  input  logic     cell_fall,
  output logic     fire
);
  logic pin_prev;
  logic cell_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_prev  <= 1'b0;
      cell_prev <= 1'b0;
    end else begin
      pin_prev  <= pin_s;
      cell_prev <= cell_term;
    end
  end

  always_comb begin
    if (src == CLK_CELL)
      fire = cell_fall ? (cell_prev & ~cell_term) : (~cell_prev & cell_term);
    else
      fire = pin_s & ~pin_prev;
  end
endmodule

// File: rtl/pld_mc_reg.sv
module pld_mc_reg (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic d_in,
  input  logic toggle_mode,
  input  logic set_n,
  input  logic clr_n,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= 1'b0;
    else if (!clr_n)
      q <= 1'b0;
    else if (!set_n)
      q <= 1'b1;
    else if (fire)
      q <= toggle_mode ? (q ^ d_in) : d_in;
  end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pld_mc_pkg::*;
#(
  parameter int NIN   = 8,
  parameter int NTERM = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NIN-1:0]            in_vec,
  input  logic                      clk_pin,
  input  logic [NTERM*(NIN+1)-1:0]  cfg_sum_true,
  input  logic [NTERM*(NIN+1)-1:0]  cfg_sum_inv,
  input  logic [SIDE_N*(NIN+1)-1:0] cfg_side_true,
  input  logic [SIDE_N*(NIN+1)-1:0] cfg_side_inv,
  input  logic                      cfg_toggle,
  input  logic                      cfg_arr_clk,
  input  logic                      cfg_aclk_fall,
  input  logic                      cfg_comb,
  output logic                      pin_data,
  output logic                      pin_oe,
  output logic                      fb_out
);
  localparam int NA = NIN + 1;

  logic [NA-1:0]     arr_s;
  logic [NTERM-1:0]  sum_hit;
  logic [SIDE_N-1:0] side_hit;
  logic              sum_val;
  logic              set_n;
  logic              clr_n;
  logic              fire;
  logic              q_r;
  logic              data_q;
  logic              oe_q;
  clk_src_e          src;

  // Input sampling stage: all terms see registered, glitch-free inputs
  always_ff @(posedge clk) begin
    if (rst) arr_s <= '0;
    else     arr_s <= {clk_pin, in_vec};
  end

  for (genvar i = 0; i < NTERM; i++) begin : g_sum
    pld_pterm #(.NA(NA)) u_term (
      .arr_in    (arr_s),
      .true_mask (cfg_sum_true[i*NA +: NA]),
      .inv_mask  (cfg_sum_inv[i*NA +: NA]),
      .hit       (sum_hit[i])
    );
  end

  for (genvar j = 0; j < SIDE_N; j++) begin : g_side
    pld_pterm #(.NA(NA)) u_term (
      .arr_in    (arr_s),
      .true_mask (cfg_side_true[j*NA +: NA]),
      .inv_mask  (cfg_side_inv[j*NA +: NA]),
      .hit       (side_hit[j])
    );
  end

  assign sum_val = |sum_hit;
  assign set_n   = ~side_hit[SIDE_SET];
  assign clr_n   = ~side_hit[SIDE_RST];
  assign src     = clk_src_e'(cfg_arr_clk);

  pld_edge_gen u_edge (
    .clk       (clk),
    .rst       (rst),
    .pin_s     (arr_s[NIN]),
    .cell_term (side_hit[SIDE_CLK]),
    .src       (src),
    .cell_fall (cfg_aclk_fall),
    .fire      (fire)
  );

  pld_mc_reg u_reg (
    .clk         (clk),
    .rst         (rst),
    .fire        (fire),
    .d_in        (sum_val),
    .toggle_mode (cfg_toggle),
    .set_n       (set_n),
    .clr_n       (clr_n),
    .q           (q_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      data_q <= cfg_comb ? sum_val : q_r;
      oe_q   <= side_hit[SIDE_OE];
    end
  end

  assign pin_data = data_q;
  assign pin_oe   = oe_q;
  assign fb_out   = data_q;
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk (
  input logic clk,
  input logic rst,
  input logic q_r,
  input logic fire,
  input logic sum_val,
  input logic set_n,
  input logic clr_n,
  input logic cfg_toggle
);
  // R10
  clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> !q_r);

  // R9
  set_forces_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_n && clr_n) |=> q_r);

  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!fire && set_n && clr_n) |=> $stable(q_r));

  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && cfg_toggle && sum_val && set_n && clr_n) |=> (q_r != $past(q_r)));

  // R5
  toggle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && cfg_toggle && !sum_val && set_n && clr_n) |=> $stable(q_r));
endmodule

bind pld_macrocell pld_macrocell_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .q_r        (q_r),
  .fire       (fire),
  .sum_val    (sum_val),
  .set_n      (set_n),
  .clr_n      (clr_n),
  .cfg_toggle (cfg_toggle)
);

// File: tb/pld_macrocell_bench.sv
module pld_macrocell_bench;
  localparam int NIN   = 6;
  localparam int NTERM = 2;
  localparam int NA    = NIN + 1;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NIN-1:0]       in_vec = '0;
  logic                 clk_pin = 1'b0;
  logic [NTERM*NA-1:0]  cfg_sum_true;
  logic [NTERM*NA-1:0]  cfg_sum_inv;
  logic [4*NA-1:0]      cfg_side_true;
  logic [4*NA-1:0]      cfg_side_inv;
  logic                 cfg_toggle = 1'b0;
  logic                 cfg_arr_clk = 1'b0;
  logic                 cfg_aclk_fall = 1'b0;
  logic                 cfg_comb = 1'b0;
  logic                 pin_data;
  logic                 pin_oe;
  logic                 fb_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic  data;
    logic  oe;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  event chk_ev;

  always #4 clk = ~clk;

  pld_macrocell #(.NIN(NIN), .NTERM(NTERM)) u_pld_macrocell (
    .clk           (clk),
    .rst           (rst),
    .in_vec        (in_vec),
    .clk_pin       (clk_pin),
    .cfg_sum_true  (cfg_sum_true),
    .cfg_sum_inv   (cfg_sum_inv),
    .cfg_side_true (cfg_side_true),
    .cfg_side_inv  (cfg_side_inv),
    .cfg_toggle    (cfg_toggle),
    .cfg_arr_clk   (cfg_arr_clk),
    .cfg_aclk_fall (cfg_aclk_fall),
    .cfg_comb      (cfg_comb),
    .pin_data      (pin_data),
    .pin_oe        (pin_oe),
    .fb_out        (fb_out)
  );

  // Monitor: pops each expectation and compares the ports
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (pin_data !== e.data || pin_oe !== e.oe) begin
          failures++;
          $display("FAIL %s: actual data=%b oe=%b expected data=%b oe=%b",
                   e.tag, pin_data, pin_oe, e.data, e.oe);
        end
        checks++;
        if (fb_out !== pin_data) begin
          failures++;
          $display("FAIL R13 (%s): actual fb=%b expected fb=%b",
                   e.tag, fb_out, pin_data);
        end
      end
    end
  end

  // Driver helpers
  task automatic expect_now(input logic d, input logic oe, input string tag);
    exp_t e;
    e.data = d;
    e.oe   = oe;
    e.tag  = tag;
    sb_q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  task automatic apply(input logic [NIN-1:0] v, input logic g);
    in_vec  = v;
    clk_pin = g;
    repeat (4) @(negedge clk);
  endtask

  // Input map: [0] a, [1] b, [2] cell clock, [3] set, [4] reset, [5] enable
  initial begin
    cfg_sum_true  = '0;
    cfg_sum_inv   = '0;
    cfg_side_true = '0;
    cfg_side_inv  = '0;
    // term0 = a & ~b, term1 = ~a & b  -> sum = a xor b
    cfg_sum_true[0*NA +: NA] = 7'b0000001;
    cfg_sum_inv [0*NA +: NA] = 7'b0000010;
    cfg_sum_true[1*NA +: NA] = 7'b0000010;
    cfg_sum_inv [1*NA +: NA] = 7'b0000001;
    cfg_side_true[0*NA +: NA] = 7'b0001000;
    cfg_side_true[1*NA +: NA] = 7'b0010000;
    cfg_side_true[2*NA +: NA] = 7'b0000100;
    cfg_side_true[3*NA +: NA] = 7'b0100000;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_now(1'b0, 1'b0, "R1 reset state");

    // Data mode, shared clock pin
    apply(6'b000001, 1'b0); expect_now(1'b0, 1'b0, "R4 no edge no load");
    apply(6'b000001, 1'b1); expect_now(1'b1, 1'b0, "R3 rising pin loads a^b=1");
    apply(6'b000000, 1'b0); expect_now(1'b1, 1'b0, "R4 falling pin ignored");
    apply(6'b000011, 1'b1); expect_now(1'b0, 1'b0, "R2 both true gives 0");
    apply(6'b000010, 1'b0);
    apply(6'b000010, 1'b1); expect_now(1'b1, 1'b0, "R2 second term hit");
    apply(6'b100010, 1'b0); expect_now(1'b1, 1'b1, "R11 enable term high");
    apply(6'b000000, 1'b0); expect_now(1'b1, 1'b0, "R11 enable term low");

    // Set / reset
    apply(6'b010000, 1'b0); expect_now(1'b0, 1'b0, "R9 reset term forces 0");
    apply(6'b001000, 1'b0); expect_now(1'b1, 1'b0, "R9 set term forces 1");
    apply(6'b000000, 1'b0); expect_now(1'b1, 1'b0, "R9 set value retained");
    apply(6'b011000, 1'b0); expect_now(1'b0, 1'b0, "R10 reset wins over set");
    apply(6'b000000, 1'b0); expect_now(1'b0, 1'b0, "R10 value retained");

    // Toggle mode, cell clock rising
    cfg_toggle  = 1'b1;
    cfg_arr_clk = 1'b1;
    apply(6'b000001, 1'b0); expect_now(1'b0, 1'b0, "R5 no edge no toggle");
    apply(6'b000101, 1'b0); expect_now(1'b1, 1'b0, "R6 rising term toggles");
    apply(6'b000001, 1'b0); expect_now(1'b1, 1'b0, "R6 falling term ignored");
    apply(6'b000101, 1'b0); expect_now(1'b0, 1'b0, "R5 second toggle");
    apply(6'b000000, 1'b0);
    apply(6'b000100, 1'b0); expect_now(1'b0, 1'b0, "R5 sum 0 holds");
    apply(6'b000101, 1'b0);
    apply(6'b000101, 1'b1); expect_now(1'b0, 1'b0, "R8 pin edge ignored");

    // Data mode, cell clock falling
    cfg_toggle    = 1'b0;
    cfg_aclk_fall = 1'b1;
    apply(6'b000001, 1'b0); expect_now(1'b1, 1'b0, "R7 falling term loads");
    apply(6'b000100, 1'b0); expect_now(1'b1, 1'b0, "R7 rising term ignored");
    apply(6'b000000, 1'b0); expect_now(1'b0, 1'b0, "R7 falling term loads 0");

    // Combinational mode, clock pin as a logic input
    cfg_comb = 1'b1;
    cfg_sum_true = '0;
    cfg_sum_inv  = '0;
    cfg_sum_true[1*NA +: NA] = 7'b1000000;
    apply(6'b000011, 1'b0); expect_now(1'b0, 1'b0, "R14 pin low, unused term 0");
    clk_pin = 1'b1;
    @(negedge clk);  expect_now(1'b0, 1'b0, "R12 one cycle: old value");
    @(negedge clk);  expect_now(1'b1, 1'b0, "R12 two cycles: new value");
    apply(6'b000000, 1'b0); expect_now(1'b0, 1'b0, "R14 pin low again");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule